// File: doc/BRIEF.md
# Quad DAC Command Decoder

This block sits behind the byte-level front end of a two-wire serial slave. It turns the received byte stream into register updates for a four-channel, 16-bit, double-buffered digital-to-analog converter. Every transaction opens with a control byte, which is followed by one or more pairs of data bytes, high byte first. The front end gives a byte strobe with each received byte, an acknowledge strobe when that byte's acknowledge phase closes, and a restart strobe when it sees a stop or repeated start condition.

The control byte selects a channel and a load action. The action can be: write the channel's holding register only, also load that channel's output register, or load all four output registers. A flag in the control byte turns the two data bytes into a power-down request. A reserved load code carries broadcast commands, which every device on the bus obeys whatever its address straps.

The output registers and power modes leave the block as flat buses. The holding register of a chosen channel can be read back combinationally.

Top module: `quad_dac_cmd_core`

## Requirements
- R1: A synchronous active-high reset clears every holding and output register to 0 and sets every power mode to 00 (normal). A channel that has never been written reads back 0.
- R2: Control byte fields are: bits [7:6] address select, [5:4] load code, [3] ignored, [2:1] channel (00..11 = channels 0..3), [0] power-down flag. Load code 00 writes the 16-bit word into the selected holding register and leaves every output register unchanged.
- R3: Load code 01 writes the selected holding register and loads that channel's output register with the new word, leaving the other channels unchanged.
- R4: Load code 10 writes the selected holding register and loads all four output registers, each from its holding register, with the selected channel taking the new word.
- R5: With load code 00, 01 or 10, a control byte whose bits [7:6] differ from the address strap inputs causes no register or power mode change.
- R6: With the power-down flag set, bits [15:14] of the word are stored as a pending power mode for the selected channel, and the holding data is left unchanged. When that channel is loaded, its power mode takes this value and its output register is unchanged.
- R7: Loading sample data (flag clear) into a channel's output register returns that channel's power mode to 00.
- R8: Load code 11 with control bit 2 clear loads all output registers from the holding registers, applying any pending power modes, for any address select value.
- R9: Load code 11 with bit 2 set and the flag clear writes the word into all holding and all output registers and sets all power modes to 00, for any address select value.
- R10: Load code 11 with bit 2 set and the flag set gives every channel the power mode in word bits [15:14], for any address select value.
- R11: Register updates happen only at the acknowledge strobe that follows the low data byte. Outputs change in the clock cycle after that strobe and not when the byte itself arrives.
- R12: Data byte pairs after the first reuse the same control byte. A restart strobe makes the next byte a control byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 2 | Device address straps compared with control bits [7:6] |
| byte_vld | input | 1 | One-cycle strobe: rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| ack_done | input | 1 | One-cycle strobe: acknowledge phase of the last byte ended |
| bus_restart | input | 1 | One-cycle strobe: stop or repeated start seen |
| rd_chan | input | 2 | Channel selected for readback |
| dac_flat | output | 64 | Output registers, channel 0 in bits [15:0] |
| pd_flat | output | 8 | Power modes, channel 0 in bits [1:0] |
| rd_data | output | 16 | Holding register data of channel rd_chan |

## Verification
The bench sends a command with mismatched address bits and checks that no output moves; a design that decoded without the address check would load the channel. It loads all channels while only one holding register is new, so a design that loaded every channel from the incoming word would show the wrong value on the others. It holds a low data byte before its acknowledge strobe to catch an update made early. It sends a second data pair without a new control byte, then a restart, to catch sequencing that treats bytes the wrong way. It stores a pending power mode and then broadcasts an update, so a design that applied the mode at once, or never applied it, gives a wrong power bus.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int CH_NUM  = 4;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CH_W    = $clog2(CH_NUM);
    localparam int MODE_W  = 2;

    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_MSB  = 2'd1,
        PH_LSB  = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        LD_TEMP  = 2'b00,
        LD_ONE   = 2'b01,
        LD_ALL   = 2'b10,
        LD_BCAST = 2'b11
    } load_t;

    typedef struct packed {
        logic [1:0]      addr;
        load_t           load;
        logic            spare;
        logic [CH_W-1:0] chan;
        logic            pd_flag;
    } ctrl_t;

    typedef struct packed {
        logic              wr_one;
        logic              wr_all;
        logic              ld_one;
        logic              ld_all;
        logic              pd_all;
        logic [CH_W-1:0]   chan;
        logic              pd_flag;
        logic [DATA_W-1:0] word;
    } act_t;

    typedef struct packed {
        logic              pend;
        logic [MODE_W-1:0] mode;
        logic [DATA_W-1:0] data;
    } hold_t;

    function automatic logic [MODE_W-1:0] mode_of(input logic [DATA_W-1:0] w);
        return w[DATA_W-1 -: MODE_W];
    endfunction

endpackage

// File: rtl/qdac_seq.sv
module qdac_seq
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              ack_done,
    input  logic              bus_restart,
    output phase_t            phase,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] word,
    output logic              commit
);

    phase_t            phase_q;
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] msb_q;
    logic [BYTE_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CTRL;
            ctrl_q  <= '0;
            msb_q   <= '0;
            hold_q  <= '0;
        end else begin
            if (byte_vld) begin
                hold_q <= rx_byte;
            end
            if (bus_restart) begin
                phase_q <= PH_CTRL;
            end else if (ack_done) begin
                unique case (phase_q)
                    PH_CTRL: begin
                        ctrl_q  <= ctrl_t'(hold_q);
                        phase_q <= PH_MSB;
                    end
                    PH_MSB: begin
                        msb_q   <= hold_q;
                        phase_q <= PH_LSB;
                    end
                    default: begin
                        phase_q <= PH_MSB;
                    end
                endcase
            end
        end
    end

    assign phase  = phase_q;
    assign ctrl   = ctrl_q;
    assign word   = {msb_q, hold_q};
    assign commit = ack_done && !bus_restart && (phase_q == PH_LSB);

endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
(
    input  logic              commit,
    input  ctrl_t             ctrl,
    input  logic [1:0]        addr_strap,
    input  logic [DATA_W-1:0] word,
    output act_t              act
);

    logic is_bcast;
    logic addr_hit;
    logic take;

    assign is_bcast = (ctrl.load == LD_BCAST);
    assign addr_hit = (ctrl.addr == addr_strap);
    assign take     = commit && (is_bcast || addr_hit);

    always_comb begin
        act         = '0;
        act.chan    = ctrl.chan;
        act.pd_flag = ctrl.pd_flag;
        act.word    = word;
        if (take) begin
            unique case (ctrl.load)
                LD_TEMP: act.wr_one = 1'b1;
                LD_ONE: begin
                    act.wr_one = 1'b1;
                    act.ld_one = 1'b1;
                end
                LD_ALL: begin
                    act.wr_one = 1'b1;
                    act.ld_all = 1'b1;
                end
                default: begin
                    if (!ctrl.chan[CH_W-1]) begin
                        act.ld_all = 1'b1;
                    end else if (!ctrl.pd_flag) begin
                        act.wr_all = 1'b1;
                        act.ld_all = 1'b1;
                    end else begin
                        act.pd_all = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
#(
    parameter int NCH = CH_NUM,
    parameter int DW  = DATA_W,
    localparam int CW = $clog2(NCH)
) (
    input  logic               clk,
    input  logic               rst,
    input  act_t               act,
    input  logic [CW-1:0]      rd_chan,
    output logic [NCH*DW-1:0]  dac_flat,
    output logic [NCH*MODE_W-1:0] pd_flat,
    output logic [DW-1:0]      rd_data
);

    logic [DW-1:0] rd_arr [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        hold_t             tmp_q;
        hold_t             tmp_new;
        hold_t             src;
        logic [DW-1:0]     dac_q;
        logic [MODE_W-1:0] pd_q;
        logic              sel;
        logic              wr;
        logic              ld;

        assign sel = (act.chan == CW'(g));
        assign wr  = (act.wr_one && sel) || act.wr_all;
        assign ld  = (act.ld_one && sel) || act.ld_all;

        always_comb begin
            tmp_new = tmp_q;
            if (act.pd_flag && !act.wr_all) begin
                tmp_new.pend = 1'b1;
                tmp_new.mode = mode_of(act.word);
            end else begin
                tmp_new.pend = 1'b0;
                tmp_new.data = act.word[DW-1:0];
            end
            src = wr ? tmp_new : tmp_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                tmp_q <= '0;
                dac_q <= '0;
                pd_q  <= '0;
            end else begin
                if (wr) begin
                    tmp_q <= tmp_new;
                end
                if (act.pd_all) begin
                    pd_q <= mode_of(act.word);
                end else if (ld) begin
                    if (src.pend) begin
                        pd_q <= src.mode;
                    end else begin
                        dac_q <= src.data;
                        pd_q  <= '0;
                    end
                end
            end
        end

        assign dac_flat[g*DW +: DW]         = dac_q;
        assign pd_flat[g*MODE_W +: MODE_W]  = pd_q;
        assign rd_arr[g]                    = tmp_q.data;
    end

    assign rd_data = rd_arr[rd_chan];

endmodule

// File: rtl/quad_dac_cmd_core.sv
module quad_dac_cmd_core
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               addr_strap,
    input  logic                     byte_vld,
    input  logic [BYTE_W-1:0]        rx_byte,
    input  logic                     ack_done,
    input  logic                     bus_restart,
    input  logic [CH_W-1:0]          rd_chan,
    output logic [CH_NUM*DATA_W-1:0] dac_flat,
    output logic [CH_NUM*MODE_W-1:0] pd_flat,
    output logic [DATA_W-1:0]        rd_data
);

    phase_t            phase_w;
    ctrl_t             ctrl_w;
    logic [DATA_W-1:0] word_w;
    logic              commit_w;
    act_t              act_w;

    qdac_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .byte_vld    (byte_vld),
        .rx_byte     (rx_byte),
        .ack_done    (ack_done),
        .bus_restart (bus_restart),
        .phase       (phase_w),
        .ctrl        (ctrl_w),
        .word        (word_w),
        .commit      (commit_w)
    );

    qdac_decode u_dec (
        .commit     (commit_w),
        .ctrl       (ctrl_w),
        .addr_strap (addr_strap),
        .word       (word_w),
        .act        (act_w)
    );

    qdac_bank #(
        .NCH (CH_NUM),
        .DW  (DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .act      (act_w),
        .rd_chan  (rd_chan),
        .dac_flat (dac_flat),
        .pd_flat  (pd_flat),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
    import qdac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     ack_done,
    input logic                     bus_restart,
    input logic                     commit,
    input ctrl_t                    ctrl,
    input logic [1:0]               addr_strap,
    input logic [DATA_W-1:0]        word,
    input phase_t                   phase,
    input logic [CH_NUM*DATA_W-1:0] dac_flat,
    input logic [CH_NUM*MODE_W-1:0] pd_flat
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dac_flat == '0 && pd_flat == '0));

    // R11
    update_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(ack_done) && !$past(rst)) |-> ($stable(dac_flat) && $stable(pd_flat)));

    // R5
    addr_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && ctrl.load != LD_BCAST && ctrl.addr != addr_strap)
        |=> ($stable(dac_flat) && $stable(pd_flat)));

    // R10
    bcast_pd_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && ctrl.load == LD_BCAST && ctrl.chan[CH_W-1] && ctrl.pd_flag)
        |=> (pd_flat == {CH_NUM{$past(word[DATA_W-1 -: MODE_W])}}));

    // R12
    restart_phase_chk: assert property (@(posedge clk) disable iff (rst)
        bus_restart |=> (phase == PH_CTRL));

endmodule

bind quad_dac_cmd_core qdac_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ack_done    (ack_done),
    .bus_restart (bus_restart),
    .commit      (commit_w),
    .ctrl        (ctrl_w),
    .addr_strap  (addr_strap),
    .word        (word_w),
    .phase       (phase_w),
    .dac_flat    (dac_flat),
    .pd_flat     (pd_flat)
);

// File: tb/quad_dac_cmd_core_tb.sv
module quad_dac_cmd_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr_strap = 2'b10;
    logic        byte_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        ack_done = 1'b0;
    logic        bus_restart = 1'b0;
    logic [1:0]  rd_chan = '0;
    logic [63:0] dac_flat;
    logic [7:0]  pd_flat;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    quad_dac_cmd_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .addr_strap  (addr_strap),
        .byte_vld    (byte_vld),
        .rx_byte     (rx_byte),
        .ack_done    (ack_done),
        .bus_restart (bus_restart),
        .rd_chan     (rd_chan),
        .dac_flat    (dac_flat),
        .pd_flat     (pd_flat),
        .rd_data     (rd_data)
    );

    // {ctrl[7:0], word[15:0], expected dac_flat[63:0], expected pd_flat[7:0]}
    localparam logic [95:0] VEC [10] = '{
        {8'h80, 16'h1111, 64'h0000_0000_0000_0000, 8'h00}, // R2
        {8'h92, 16'h2222, 64'h0000_0000_2222_0000, 8'h00}, // R3
        {8'h54, 16'h3333, 64'h0000_0000_2222_0000, 8'h00}, // R5
        {8'hA6, 16'h4444, 64'h4444_0000_2222_1111, 8'h00}, // R4
        {8'h91, 16'h8000, 64'h4444_0000_2222_1111, 8'h02}, // R6
        {8'h90, 16'h5555, 64'h4444_0000_2222_5555, 8'h00}, // R7
        {8'h35, 16'hC000, 64'h4444_0000_2222_5555, 8'hFF}, // R10
        {8'h34, 16'h6666, 64'h6666_6666_6666_6666, 8'h00}, // R9
        {8'h84, 16'h7777, 64'h6666_6666_6666_6666, 8'h00}, // R2
        {8'h70, 16'h0000, 64'h6666_7777_6666_6666, 8'h00}  // R8
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        ack_done = 1'b1;
        @(negedge clk);
        ack_done = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        put_byte(b);
        ack();
    endtask

    task automatic restart();
        @(negedge clk);
        bus_restart = 1'b1;
        @(negedge clk);
        bus_restart = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] c, input logic [15:0] w);
        restart();
        send(c);
        send(w[15:8]);
        send(w[7:0]);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state and blank readback
        chk("R1 dac after reset", dac_flat, 64'h0);
        chk("R1 pd after reset", {56'h0, pd_flat}, 64'h0);
        rd_chan = 2'd2;
        #1;
        chk("R1 readback never written", {48'h0, rd_data}, 64'h0);

        for (int i = 0; i < 10; i++) begin
            xfer(VEC[i][95:88], VEC[i][87:72]);
            chk($sformatf("vector %0d dac", i), dac_flat, VEC[i][71:8]);
            chk($sformatf("vector %0d pd", i), {56'h0, pd_flat}, {56'h0, VEC[i][7:0]});
        end

        // R2: holding register written by load code 00
        rd_chan = 2'd2;
        #1;
        chk("R2 readback ch2", {48'h0, rd_data}, 64'h7777);

        // R11: no update before the acknowledge of the low byte
        restart();
        send(8'h92);
        send(8'h9A);
        put_byte(8'hBC);
        @(negedge clk);
        chk("R11 before ack", dac_flat[31:16], 64'h6666);
        ack();
        chk("R11 after ack", dac_flat[31:16], 64'h9ABC);

        // R12: repeated data pairs and restart
        xfer(8'h90, 16'h1234);
        chk("R12 first pair", dac_flat[15:0], 64'h1234);
        send(8'hAB);
        send(8'hCD);
        @(negedge clk);
        chk("R12 repeated pair", dac_flat[15:0], 64'hABCD);
        xfer(8'h96, 16'h0F0F);
        chk("R12 restart control", dac_flat[63:48], 64'h0F0F);
        chk("R12 ch0 untouched", dac_flat[15:0], 64'hABCD);

        // R6 / R8: pending power mode applied by broadcast update
        xfer(8'h87, 16'h4000);
        chk("R6 pending not applied", {56'h0, pd_flat}, 64'h0);
        xfer(8'h70, 16'h0000);
        chk("R8 pending mode applied", {56'h0, pd_flat}, 64'h40);
        chk("R8 dac from holding", dac_flat, 64'h0F0F_7777_9ABC_ABCD);
        rd_chan = 2'd3;
        #1;
        chk("R6 data kept on pd write", {48'h0, rd_data}, 64'h0F0F);

        // R1: reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 dac after second reset", dac_flat, 64'h0);
        chk("R1 pd after second reset", {56'h0, pd_flat}, 64'h0);
        chk("R1 readback after second reset", {48'h0, rd_data}, 64'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule